// File: doc/BRIEF.md
# Dual Register-Set DMA Channel Sequencer

This block sequences one DMA channel. It holds two descriptor sets, set 0 and set 1. Each set stores a source address, a destination address and a total byte count. Once the channel is armed, a working copy of the active set walks both addresses and counts the remaining bytes down. Each data unit is issued as one command, holding both addresses and a byte count, on a ready/valid port toward the memory side. That side does the actual read and write.

Transfers are started by a hardware request strobe or by software. A software start can run a single unit or repeat until the count is exhausted. In normal mode each accepted start moves one unit. In block mode one start moves units until the active descriptor is finished. When a descriptor completes, the channel either stops (once) or switches to the other set and continues from there (alternate). Software may rewrite the idle set at any time, and the new values are used when the channel next switches to that set. The `active_set` output tells software which set is in use. A programmable interval adds idle cycles between units. Lowering the enable input stops new units from starting, but a unit already on the port still completes.

Top module: `dual_set_dma_seq`

## Requirements
- R1: A size code c (3 bits, 0..7) means a unit of 2^c bytes (1 to 128). `cmd_bytes` equals the source unit size, or the remaining byte count when that is smaller. `cmd_src_size`/`cmd_dst_size` carry the configured codes.
- R2: After each accepted unit, a side with its increment bit at 1 advances by its own unit size in bytes. A side with its increment bit at 0 keeps the same address.
- R3: In normal mode (`cfg_block`=0), each request strobe accepted while the channel is idle and armed produces exactly one command.
- R4: In block mode (`cfg_block`=1), one accepted request produces commands until the active descriptor's byte count reaches zero.
- R5: The remaining count drops by `cmd_bytes` on every handshake. Once it is zero, no request or software start produces a command.
- R6: On the handshake that brings the count to zero, `irq_end` pulses high for one cycle on the following cycle, provided `cfg_irq_en`=1. It stays low when `cfg_irq_en`=0.
- R7: With `cfg_alternate`=0, only set 0 runs and `active_set` stays 0. With `cfg_alternate`=1, completing a set loads the other set and toggles `active_set`.
- R8: A descriptor write to the set that is not active is stored and used at the next switch to that set. A write to the active set while the channel is armed is ignored.
- R9: `sw_start` with `sw_repeat`=0 moves one unit. With `sw_repeat`=1 it moves units until the count is exhausted, and a `sw_stop` pulse ends the run after any unit in progress.
- R10: Within a run with `cmd_ready` held high, consecutive commands are separated by exactly `cfg_interval`+1 cycles with `cmd_valid` low.
- R11: While `chan_en` is low, no new command starts, and a command already on the port stays valid with `busy` high until it is accepted. When the channel is idle with `chan_en` low, it disarms. Raising `chan_en` again reloads set 0.
- R12: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and the command fields stay unchanged.
- R13: After reset, `cmd_valid`, `busy`, `irq_end` and `active_set` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; arms from set 0 when raised |
| req | input | 1 | Hardware request strobe |
| sw_start | input | 1 | Software start strobe |
| sw_repeat | input | 1 | With sw_start: 1 = repeat until exhausted, 0 = single unit |
| sw_stop | input | 1 | Software stop strobe for repeated runs |
| cfg_src_size | input | 3 | Source unit size code |
| cfg_dst_size | input | 3 | Destination unit size code |
| cfg_src_inc | input | 1 | 1 = increment source address |
| cfg_dst_inc | input | 1 | 1 = increment destination address |
| cfg_block | input | 1 | 1 = block mode, 0 = normal mode |
| cfg_alternate | input | 1 | 1 = alternate between the sets, 0 = run set 0 once |
| cfg_irq_en | input | 1 | Enable for the end-of-transfer pulse |
| cfg_interval | input | IVL_W | Idle cycles inserted between units |
| ld_valid | input | 1 | Descriptor write strobe |
| ld_set | input | 1 | Target set of the descriptor write |
| ld_src | input | ADDR_W | Source address to write |
| ld_dst | input | ADDR_W | Destination address to write |
| ld_len | input | CNT_W | Total byte count to write |
| cmd_valid | output | 1 | Unit command valid |
| cmd_ready | input | 1 | Unit command accepted by memory side |
| cmd_src_addr | output | ADDR_W | Read address of the unit |
| cmd_dst_addr | output | ADDR_W | Write address of the unit |
| cmd_src_size | output | 3 | Source size code |
| cmd_dst_size | output | 3 | Destination size code |
| cmd_bytes | output | 8 | Bytes moved by this unit |
| irq_end | output | 1 | End-of-transfer pulse |
| busy | output | 1 | A unit is in flight or the interval is running |
| active_set | output | 1 | Descriptor set in use |

## Verification
The assertions rely on a few properties of the inputs. Configuration fields must be held steady while the channel is busy, since the end pulse is checked against `cfg_irq_en` from the cycle before. The command consumer may stall for any number of cycles, and the hold checks are written with that in mind. The stimulus follows these rules: it changes configuration and descriptors only while the channel is idle (reloads excepted), drives every strobe for exactly one clock edge, and moves `chan_en` at arbitrary points relative to the command port, as the disable and hold scenarios require.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  localparam int SIZE_W = 3;
  localparam int UNIT_W = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;

  function automatic logic [UNIT_W-1:0] unit_bytes(input logic [SIZE_W-1:0] code);
    return UNIT_W'(1) << code;
  endfunction
endpackage

// File: rtl/dsq_desc_bank.sv
module dsq_desc_bank #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [AW-1:0] wr_src,
  input  logic [AW-1:0] wr_dst,
  input  logic [CW-1:0] wr_len,
  input  logic          lock_en,
  input  logic          lock_sel,
  input  logic          rd_sel,
  output logic [AW-1:0] rd_src,
  output logic [AW-1:0] rd_dst,
  output logic [CW-1:0] rd_len
);
  localparam int NSETS = 2;

  logic [AW-1:0] src_all [NSETS];
  logic [AW-1:0] dst_all [NSETS];
  logic [CW-1:0] len_all [NSETS];

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic          hit;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [CW-1:0] len_q;

    // a set in use by the armed channel is write-protected
    assign hit = wr_en && (wr_sel == 1'(g)) && !(lock_en && (lock_sel == 1'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q <= '0;
        dst_q <= '0;
        len_q <= '0;
      end else if (hit) begin
        src_q <= wr_src;
        dst_q <= wr_dst;
        len_q <= wr_len;
      end
    end

    assign src_all[g] = src_q;
    assign dst_all[g] = dst_q;
    assign len_all[g] = len_q;
  end

  assign rd_src = src_all[rd_sel];
  assign rd_dst = dst_all[rd_sel];
  assign rd_len = len_all[rd_sel];
endmodule

// File: rtl/dsq_addr_walk.sv
module dsq_addr_walk
  import dsq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [AW-1:0]     load_src,
  input  logic [AW-1:0]     load_dst,
  input  logic [CW-1:0]     load_len,
  input  logic              step_en,
  input  logic [SIZE_W-1:0] src_code,
  input  logic [SIZE_W-1:0] dst_code,
  input  logic              src_inc,
  input  logic              dst_inc,
  output logic [AW-1:0]     cur_src,
  output logic [AW-1:0]     cur_dst,
  output logic [UNIT_W-1:0] unit_len,
  output logic              has_work,
  output logic              is_last
);
  logic [AW-1:0]     src_q, src_d;
  logic [AW-1:0]     dst_q, dst_d;
  logic [CW-1:0]     len_q, len_d;
  logic [UNIT_W-1:0] src_ub, dst_ub;

  always_comb begin
    src_ub   = unit_bytes(src_code);
    dst_ub   = unit_bytes(dst_code);
    is_last  = (len_q <= CW'(src_ub));
    unit_len = is_last ? len_q[UNIT_W-1:0] : src_ub;
    src_d    = src_q;
    dst_d    = dst_q;
    len_d    = len_q;
    if (load_en) begin
      src_d = load_src;
      dst_d = load_dst;
      len_d = load_len;
    end else if (step_en) begin
      if (src_inc) src_d = src_q + AW'(src_ub);
      if (dst_inc) dst_d = dst_q + AW'(dst_ub);
      len_d = len_q - CW'(unit_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
    end else if (load_en || step_en) begin
      src_q <= src_d;
      dst_q <= dst_d;
      len_q <= len_d;
    end
  end

  assign cur_src  = src_q;
  assign cur_dst  = dst_q;
  assign has_work = (len_q != '0);
endmodule

// File: rtl/dsq_seq_ctrl.sv
module dsq_seq_ctrl
  import dsq_pkg::*;
#(
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          req,
  input  logic          sw_start,
  input  logic          sw_repeat,
  input  logic          sw_stop,
  input  logic          cfg_block,
  input  logic          cfg_alternate,
  input  logic          cfg_irq_en,
  input  logic [IW-1:0] cfg_interval,
  input  logic          cmd_ready,
  input  logic          has_work,
  input  logic          is_last,
  output logic          cmd_valid,
  output logic          busy,
  output logic          irq_end,
  output logic          step_en,
  output logic          load_en,
  output logic          load_sel,
  output logic          active_set,
  output logic          armed
);
  seq_state_e    state_q, state_d;
  logic [IW-1:0] gap_q, gap_d;
  logic          armed_q, armed_d;
  logic          burst_q, burst_d;
  logic          rpt_q, rpt_d;
  logic          set_q, set_d;
  logic          irq_q, irq_d;
  logic          idle, arm_ld, disarm, hs, fin, swap, trig, can_go, go;

  always_comb begin
    idle   = (state_q == SEQ_IDLE);
    arm_ld = idle && chan_en && !armed_q;
    disarm = idle && !chan_en;
    hs     = (state_q == SEQ_ISSUE) && cmd_ready;
    fin    = hs && is_last;
    swap   = fin && cfg_alternate;
    trig   = req || (sw_start && !sw_repeat);
    can_go = armed_q && chan_en && has_work;
    go     = idle && can_go && (trig || burst_q || rpt_q);

    state_d = state_q;
    gap_d   = gap_q;
    unique case (state_q)
      SEQ_IDLE:  if (go) state_d = SEQ_ISSUE;
      SEQ_ISSUE: if (hs) begin
                   if (cfg_interval == '0) begin
                     state_d = SEQ_IDLE;
                   end else begin
                     state_d = SEQ_GAP;
                     gap_d   = cfg_interval;
                   end
                 end
      SEQ_GAP:   if (gap_q == IW'(1)) state_d = SEQ_IDLE;
                 else gap_d = gap_q - IW'(1);
      default:   state_d = SEQ_IDLE;
    endcase

    armed_d = arm_ld ? 1'b1 : (disarm ? 1'b0 : armed_q);

    burst_d = burst_q;
    if (disarm || fin) burst_d = 1'b0;
    else if (idle && can_go && trig && cfg_block) burst_d = 1'b1;

    rpt_d = rpt_q;
    if (disarm || fin || sw_stop) rpt_d = 1'b0;
    else if (sw_start && sw_repeat) rpt_d = 1'b1;

    set_d = arm_ld ? 1'b0 : (swap ? ~set_q : set_q);
    irq_d = fin && cfg_irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      gap_q   <= '0;
      armed_q <= 1'b0;
      burst_q <= 1'b0;
      rpt_q   <= 1'b0;
      set_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      armed_q <= armed_d;
      burst_q <= burst_d;
      rpt_q   <= rpt_d;
      set_q   <= set_d;
      irq_q   <= irq_d;
    end
  end

  assign cmd_valid  = (state_q == SEQ_ISSUE);
  assign busy       = !idle;
  assign irq_end    = irq_q;
  assign step_en    = hs;
  assign load_en    = arm_ld || swap;
  assign load_sel   = arm_ld ? 1'b0 : ~set_q;
  assign active_set = set_q;
  assign armed      = armed_q;
endmodule

// File: rtl/dual_set_dma_seq.sv
module dual_set_dma_seq
  import dsq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int IVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              req,
  input  logic              sw_start,
  input  logic              sw_repeat,
  input  logic              sw_stop,
  input  logic [2:0]        cfg_src_size,
  input  logic [2:0]        cfg_dst_size,
  input  logic              cfg_src_inc,
  input  logic              cfg_dst_inc,
  input  logic              cfg_block,
  input  logic              cfg_alternate,
  input  logic              cfg_irq_en,
  input  logic [IVL_W-1:0]  cfg_interval,
  input  logic              ld_valid,
  input  logic              ld_set,
  input  logic [ADDR_W-1:0] ld_src,
  input  logic [ADDR_W-1:0] ld_dst,
  input  logic [CNT_W-1:0]  ld_len,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_src_addr,
  output logic [ADDR_W-1:0] cmd_dst_addr,
  output logic [2:0]        cmd_src_size,
  output logic [2:0]        cmd_dst_size,
  output logic [7:0]        cmd_bytes,
  output logic              irq_end,
  output logic              busy,
  output logic              active_set
);
  logic              rst_meta, rst_sync;
  logic              load_en, load_sel, step_en, armed, has_work, is_last;
  logic [ADDR_W-1:0] bank_src, bank_dst;
  logic [CNT_W-1:0]  bank_len;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dsq_desc_bank #(.AW(ADDR_W), .CW(CNT_W)) i_bank (
    .clk(clk), .rst_n(rst_sync),
    .wr_en(ld_valid), .wr_sel(ld_set),
    .wr_src(ld_src), .wr_dst(ld_dst), .wr_len(ld_len),
    .lock_en(armed), .lock_sel(active_set),
    .rd_sel(load_sel),
    .rd_src(bank_src), .rd_dst(bank_dst), .rd_len(bank_len)
  );

  dsq_addr_walk #(.AW(ADDR_W), .CW(CNT_W)) i_walk (
    .clk(clk), .rst_n(rst_sync),
    .load_en(load_en), .load_src(bank_src), .load_dst(bank_dst), .load_len(bank_len),
    .step_en(step_en),
    .src_code(cfg_src_size), .dst_code(cfg_dst_size),
    .src_inc(cfg_src_inc), .dst_inc(cfg_dst_inc),
    .cur_src(cmd_src_addr), .cur_dst(cmd_dst_addr),
    .unit_len(cmd_bytes), .has_work(has_work), .is_last(is_last)
  );

  dsq_seq_ctrl #(.IW(IVL_W)) i_ctrl (
    .clk(clk), .rst_n(rst_sync),
    .chan_en(chan_en), .req(req),
    .sw_start(sw_start), .sw_repeat(sw_repeat), .sw_stop(sw_stop),
    .cfg_block(cfg_block), .cfg_alternate(cfg_alternate),
    .cfg_irq_en(cfg_irq_en), .cfg_interval(cfg_interval),
    .cmd_ready(cmd_ready), .has_work(has_work), .is_last(is_last),
    .cmd_valid(cmd_valid), .busy(busy), .irq_end(irq_end),
    .step_en(step_en), .load_en(load_en), .load_sel(load_sel),
    .active_set(active_set), .armed(armed)
  );

  assign cmd_src_size = cfg_src_size;
  assign cmd_dst_size = cfg_dst_size;
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          cfg_irq_en,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [AW-1:0] cmd_src_addr,
  input logic [AW-1:0] cmd_dst_addr,
  input logic [7:0]    cmd_bytes,
  input logic          irq_end,
  input logic          busy
);
  AST_HOLD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src_addr)
                                && $stable(cmd_dst_addr) && $stable(cmd_bytes)); // R12

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) |-> $past(chan_en)); // R11

  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> busy); // R11

  AST_IRQ_AFTER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> $past(cmd_valid && cmd_ready && cfg_irq_en)); // R6

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |=> !irq_end); // R6

  AST_GAP_AFTER_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid); // R10

  AST_NONZERO_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_bytes != 8'd0); // R5
endmodule

bind dual_set_dma_seq dsq_checker #(.AW(ADDR_W)) i_dsq_checker (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_irq_en(cfg_irq_en),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_src_addr(cmd_src_addr), .cmd_dst_addr(cmd_dst_addr),
  .cmd_bytes(cmd_bytes), .irq_end(irq_end), .busy(busy)
);

// File: tb/test_dual_set_dma_seq.sv
module test_dual_set_dma_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        chan_en, req, sw_start, sw_repeat, sw_stop;
  logic [2:0]  cfg_src_size, cfg_dst_size;
  logic        cfg_src_inc, cfg_dst_inc, cfg_block, cfg_alternate, cfg_irq_en;
  logic [7:0]  cfg_interval;
  logic        ld_valid, ld_set;
  logic [31:0] ld_src, ld_dst, ld_len;
  logic        cmd_valid, cmd_ready;
  logic [31:0] cmd_src_addr, cmd_dst_addr;
  logic [2:0]  cmd_src_size, cmd_dst_size;
  logic [7:0]  cmd_bytes;
  logic        irq_end, busy, active_set;

  int n_chk = 0, n_fail = 0;
  int hs_n = 0, irq_n = 0, irq_hs = 0, cyc = 0;
  logic [31:0] log_src [64];
  logic [31:0] log_dst [64];
  int          log_bytes [64];
  int          log_cyc [64];

  dual_set_dma_seq i_dual_set_dma_seq (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (cmd_valid === 1'b1 && cmd_ready === 1'b1) begin
      if (hs_n < 64) begin
        log_src[hs_n]   = cmd_src_addr;
        log_dst[hs_n]   = cmd_dst_addr;
        log_bytes[hs_n] = int'(cmd_bytes);
        log_cyc[hs_n]   = cyc;
      end
      hs_n++;
    end
    if (irq_end === 1'b1) begin
      irq_n++;
      irq_hs = hs_n;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic prog(input logic s, input logic [31:0] src, input logic [31:0] dst,
                      input logic [31:0] len);
    ld_set = s; ld_src = src; ld_dst = dst; ld_len = len; ld_valid = 1'b1;
    tick(1);
    ld_valid = 1'b0;
  endtask

  task automatic pulse_req();
    req = 1'b1; tick(1); req = 1'b0;
  endtask

  task automatic pulse_start(input logic rep);
    sw_repeat = rep; sw_start = 1'b1; tick(1); sw_start = 1'b0;
  endtask

  task automatic config_ch(input logic [2:0] ss, input logic [2:0] ds, input logic si,
                           input logic di, input logic blk, input logic alt,
                           input logic irq, input logic [7:0] ivl);
    cfg_src_size = ss; cfg_dst_size = ds; cfg_src_inc = si; cfg_dst_inc = di;
    cfg_block = blk; cfg_alternate = alt; cfg_irq_en = irq; cfg_interval = ivl;
  endtask

  task automatic rearm_set0(input logic [31:0] src, input logic [31:0] dst,
                            input logic [31:0] len);
    chan_en = 1'b0; tick(2);
    prog(1'b0, src, dst, len);
    chan_en = 1'b1; tick(3);
  endtask

  task automatic t_reset();
    chk("R13 cmd_valid", cmd_valid, 0);
    chk("R13 busy", busy, 0);
    chk("R13 irq_end", irq_end, 0);
    chk("R13 active_set", active_set, 0);
  endtask

  task automatic t_normal();
    int b, ib;
    config_ch(3'd2, 3'd0, 1, 1, 0, 0, 1, 8'd0);
    rearm_set0(32'h100, 32'h200, 32'd12);
    b = hs_n; ib = irq_n;
    for (int k = 0; k < 3; k++) begin
      pulse_req(); tick(6);
      chk("R3 one unit per request", hs_n - b, k + 1);
    end
    chk("R2 src inc 4 #0", log_src[b], 32'h100);
    chk("R2 src inc 4 #2", log_src[b+2], 32'h108);
    chk("R2 dst inc 1 #1", log_dst[b+1], 32'h201);
    chk("R2 dst inc 1 #2", log_dst[b+2], 32'h202);
    chk("R1 unit bytes 4", log_bytes[b+1], 4);
    chk("R6 one end pulse", irq_n - ib, 1);
    chk("R6 pulse after last unit", irq_hs, b + 3);
    pulse_req(); tick(6);
    chk("R5 no unit at zero count", hs_n - b, 3);
    chk("R7 once keeps set 0", active_set, 0);
  endtask

  task automatic t_block();
    int b, ib;
    config_ch(3'd2, 3'd3, 0, 1, 1, 0, 0, 8'd2);
    rearm_set0(32'h300, 32'h400, 32'd10);
    b = hs_n; ib = irq_n;
    pulse_req(); tick(30);
    chk("R4 block units per request", hs_n - b, 3);
    chk("R2 src fixed", log_src[b+2], 32'h300);
    chk("R2 dst inc 8", log_dst[b+2], 32'h410);
    chk("R1 clamp last unit", log_bytes[b+2], 2);
    chk("R5 bytes first unit", log_bytes[b], 4);
    chk("R10 interval 2 spacing", log_cyc[b+1] - log_cyc[b], 4);
    chk("R10 interval 2 spacing b", log_cyc[b+2] - log_cyc[b+1], 4);
    chk("R6 masked end pulse", irq_n - ib, 0);
  endtask

  task automatic t_alternate();
    int b, ib;
    config_ch(3'd2, 3'd2, 1, 1, 1, 1, 1, 8'd0);
    chan_en = 1'b0; tick(2);
    prog(1'b0, 32'h1000, 32'h2000, 32'd8);
    prog(1'b1, 32'h3000, 32'h4000, 32'd4);
    chan_en = 1'b1; tick(3);
    prog(1'b1, 32'h3800, 32'h4800, 32'd4);
    prog(1'b0, 32'h7000, 32'h7800, 32'd4);
    b = hs_n; ib = irq_n;
    pulse_req(); tick(10);
    chk("R7 set 0 block", hs_n - b, 2);
    chk("R7 set 0 addr", log_src[b+1], 32'h1004);
    chk("R7 switched to set 1", active_set, 1);
    pulse_req(); tick(10);
    chk("R8 idle reload used", log_src[b+2], 32'h3800);
    chk("R8 idle reload dst", log_dst[b+2], 32'h4800);
    chk("R7 back to set 0", active_set, 0);
    pulse_req(); tick(10);
    chk("R8 active write ignored", log_src[b+3], 32'h1000);
    chk("R8 active write ignored len", hs_n - b, 5);
    chk("R6 end pulse per set", irq_n - ib, 3);
  endtask

  task automatic t_software();
    int b, ok;
    config_ch(3'd2, 3'd2, 1, 1, 0, 0, 0, 8'd0);
    rearm_set0(32'h500, 32'h600, 32'd16);
    b = hs_n;
    cmd_ready = 1'b0;
    pulse_start(1'b0); tick(3);
    chk("R12 valid held", cmd_valid, 1);
    chk("R12 addr held", cmd_src_addr, 32'h500);
    tick(2);
    chk("R12 valid still held", cmd_valid, 1);
    chk("R12 addr still held", cmd_src_addr, 32'h500);
    cmd_ready = 1'b1; tick(4);
    chk("R9 single start one unit", hs_n - b, 1);
    pulse_start(1'b1); tick(15);
    chk("R9 repeat runs to end", hs_n - b, 4);
    chk("R9 repeat last addr", log_src[b+3], 32'h50C);
    cfg_interval = 8'd10;
    rearm_set0(32'h800, 32'h900, 32'd40);
    b = hs_n; ok = 0;
    pulse_start(1'b1);
    for (int k = 0; k < 40 && ok == 0; k++) begin
      tick(1);
      if (hs_n - b >= 2) ok = 1;
    end
    sw_stop = 1'b1; tick(1); sw_stop = 1'b0;
    tick(40);
    chk("R9 stop ends repeat", hs_n - b, 2);
    chk("R9 idle after stop", busy, 0);
  endtask

  task automatic t_disable();
    int b;
    config_ch(3'd2, 3'd2, 1, 1, 1, 0, 0, 8'd0);
    rearm_set0(32'hA00, 32'hB00, 32'd16);
    b = hs_n;
    cmd_ready = 1'b0;
    pulse_req(); tick(2);
    chk("R11 command issued", cmd_valid, 1);
    chan_en = 1'b0; tick(3);
    chk("R11 busy while pending", busy, 1);
    chk("R11 valid while pending", cmd_valid, 1);
    cmd_ready = 1'b1; tick(8);
    chk("R11 pending unit completes only", hs_n - b, 1);
    chk("R11 busy drops", busy, 0);
    chan_en = 1'b1; tick(3);
    pulse_req(); tick(12);
    chk("R11 reenable restarts set 0", log_src[b+1], 32'hA00);
    chk("R11 reenable full block", hs_n - b, 5);
  endtask

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; req = 1'b0; sw_start = 1'b0; sw_repeat = 1'b0;
    sw_stop = 1'b0; ld_valid = 1'b0; ld_set = 1'b0; ld_src = '0; ld_dst = '0;
    ld_len = '0; cmd_ready = 1'b1;
    config_ch(3'd0, 3'd0, 0, 0, 0, 0, 0, 8'd0);
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_normal();
    t_block();
    t_alternate();
    t_software();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule